// File: doc/BRIEF.md
# Flag-Setting ALU with Register File

This block is a 32-bit arithmetic and logic unit built around four data registers. Each strobed operation reads one register as the destination operand. It takes a second operand either from an immediate input or from another register. It can write the result back to the destination, and it always refreshes a four-bit status word.

The supported operations are add, subtract, compare, OR, XOR and bit-test. Each one has its own rule for the carry and overflow flags. Compare and bit-test only set flags and never change a register.

Register selects arrive in a 12-bit select field. A layout input says where the two 2-bit selects sit inside that field: either in the low byte or at bits 8 to 11. All register contents and the flags are visible on the outputs, so a surrounding pipeline or a bench can observe them.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, all four registers and all four flags read zero.
- R2: Add (`op_code` 0) writes destination plus source, modulo 2^32. Carry is set when the true unsigned sum exceeds 32 bits.
- R3: Add sets overflow when both operands have the same bit 31 and the sum's bit 31 differs from it.
- R4: Subtract (`op_code` 1) writes destination minus source, modulo 2^32. Carry is set as a borrow, meaning the source is unsigned-greater than the destination.
- R5: Subtract sets overflow when the operands' bit 31 values differ and the result's bit 31 differs from the destination's bit 31.
- R6: Compare (`op_code` 2) sets all four flags as subtract would for destination minus source, and leaves every register unchanged.
- R7: OR (`op_code` 3) and XOR (`op_code` 4) write their result to the destination and clear carry and overflow.
- R8: Bit-test (`op_code` 5) ANDs destination and source. It sets Z and N from that value, clears carry and overflow, and leaves every register unchanged.
- R9: `flags` is {Z,N,C,V}, with bit 3 Z, bit 2 N, bit 1 C and bit 0 V. Every operation rewrites all four flags. Z means the 32-bit result is zero, and N is bit 31 of the result.
- R10: With `sel_hi` = 0 the destination select is `sel_fld[1:0]` and the source select is `sel_fld[3:2]`. With `sel_hi` = 1 they are `sel_fld[9:8]` and `sel_fld[11:10]`.
- R11: With `use_imm` = 1 the source operand is `imm`. With `use_imm` = 0 it is the register named by the source select.
- R12: A cycle with `op_valid` low, or with `op_code` 6 or 7, changes neither registers nor flags.
- R13: Register writeback and the flag update appear together on the rising clock edge that samples `op_valid` high, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation: 0 add, 1 sub, 2 cmp, 3 or, 4 xor, 5 bit-test |
| sel_fld | input | 12 | Field holding the destination and source register selects |
| sel_hi | input | 1 | Select layout: 0 uses bits 0..3, 1 uses bits 8..11 |
| use_imm | input | 1 | 1: source is `imm`; 0: source is a register |
| imm | input | 32 | Immediate source operand |
| flags | output | 4 | Status {Z,N,C,V} |
| regs_out | output | 128 | Register i on bits [32*i+31:32*i] |

## Verification
Every result of this block is due one clock edge after the strobe. Register writeback and all four flags land on that same edge, and nothing changes in the cycles without a valid operation. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge. At that point it compares against a behavioural model that has also taken exactly one step. One check also samples just before the rising edge, to confirm that the outputs still hold their old values there.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W    = 32,
  parameter int NREG = 4,
  parameter int SELW = $clog2(NREG),
  parameter int HIB  = 8,
  parameter int FW   = HIB + 2*SELW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [FW-1:0]     sel_fld,
  input  logic              sel_hi,
  input  logic              use_imm,
  input  logic [W-1:0]      imm,
  output logic [3:0]        flags,
  output logic [NREG*W-1:0] regs_out
);

  logic [W-1:0]    rf [NREG];
  logic [SELW-1:0] dsel, ssel;
  logic [W-1:0]    dval, sval, res;
  logic [W:0]      sum, dif;
  logic            c_nx, v_nx, wr, known;

  assign dsel = sel_hi ? sel_fld[HIB +: SELW]        : sel_fld[0 +: SELW];
  assign ssel = sel_hi ? sel_fld[HIB + SELW +: SELW] : sel_fld[SELW +: SELW];
  assign dval = rf[dsel];
  assign sval = use_imm ? imm : rf[ssel];
  assign sum  = {1'b0, dval} + {1'b0, sval};
  assign dif  = {1'b0, dval} - {1'b0, sval};

  always_comb begin
    res = '0; c_nx = 1'b0; v_nx = 1'b0; wr = 1'b0; known = 1'b1;
    case (op_code)
      3'd0: begin
        res  = sum[W-1:0];
        c_nx = sum[W];
        v_nx = (dval[W-1] == sval[W-1]) && (res[W-1] != dval[W-1]);
        wr   = 1'b1;
      end
      3'd1, 3'd2: begin
        res  = dif[W-1:0];
        c_nx = dif[W];
        v_nx = (dval[W-1] != sval[W-1]) && (res[W-1] != dval[W-1]);
        wr   = (op_code == 3'd1);
      end
      3'd3: begin res = dval | sval; wr = 1'b1; end
      3'd4: begin res = dval ^ sval; wr = 1'b1; end
      3'd5: res = dval & sval;
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (op_valid && known) begin
      flags <= {res == '0, res[W-1], c_nx, v_nx};
      if (wr) rf[dsel] <= res;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_out[g*W +: W] = rf[g];
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W    = 32,
  parameter int NREG = 4,
  parameter int SELW = 2,
  parameter int HIB  = 8,
  parameter int FW   = HIB + 2*SELW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [FW-1:0]     sel_fld,
  input logic              sel_hi,
  input logic [3:0]        flags,
  input logic [NREG*W-1:0] regs_out
);

  logic [SELW-1:0] dsel_q;
  logic [W-1:0]    dreg_now;

  always_ff @(posedge clk)
    dsel_q <= sel_hi ? sel_fld[HIB +: SELW] : sel_fld[0 +: SELW];

  assign dreg_now = regs_out[dsel_q*W +: W];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags) && $stable(regs_out)); // R12
  AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 3'd5) |=> $stable(flags) && $stable(regs_out)); // R12
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> $stable(regs_out)); // R6
  AST_BTST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5) |=> $stable(regs_out) && flags[1:0] == 2'b00); // R8
  AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd3 || op_code == 3'd4)) |=> flags[1:0] == 2'b00); // R7
  AST_ZN_MATCH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code inside {3'd0, 3'd1, 3'd3, 3'd4})
      |=> flags[3] == (dreg_now == '0) && flags[2] == dreg_now[W-1]); // R9

endmodule

bind flag_alu flag_alu_chk #(.W(W), .NREG(NREG), .SELW(SELW), .HIB(HIB), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .sel_fld(sel_fld), .sel_hi(sel_hi), .flags(flags), .regs_out(regs_out)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  logic        clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, sel_hi = 1'b0, use_imm = 1'b0;
  logic [2:0]  op_code = '0;
  logic [11:0] sel_fld = '0;
  logic [31:0] imm = '0;
  logic [3:0]  flags;
  logic [127:0] regs_out;

  int checks = 0, failures = 0;
  logic [31:0] m_rf [4];
  logic [3:0]  m_fl;

  flag_alu dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .sel_fld(sel_fld), .sel_hi(sel_hi), .use_imm(use_imm), .imm(imm),
    .flags(flags), .regs_out(regs_out));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_model(string req);
    chk(req, {28'd0, flags}, {28'd0, m_fl});
    for (int i = 0; i < 4; i++) chk(req, regs_out[i*32 +: 32], m_rf[i]);
  endtask

  task automatic model_step(logic [2:0] op, logic [11:0] f, logic hi, logic ui, logic [31:0] im);
    int d, s;
    logic [31:0] dv, sv, r;
    logic c, v, known, wr;
    longint unsigned t;
    d  = hi ? f[9:8] : f[1:0];
    s  = hi ? f[11:10] : f[3:2];
    dv = m_rf[d];
    sv = ui ? im : m_rf[s];
    c = 0; v = 0; known = 1; wr = 0; r = 0;
    if (op == 0) begin
      t = longint'(dv) + longint'(sv); r = dv + sv; c = t > 64'hFFFF_FFFF;
      v = (dv[31] == sv[31]) && (r[31] != dv[31]); wr = 1;
    end else if (op == 1 || op == 2) begin
      r = dv - sv; c = sv > dv;
      v = (dv[31] != sv[31]) && (r[31] != dv[31]); wr = (op == 1);
    end else if (op == 3) begin r = dv | sv; wr = 1; end
    else if (op == 4) begin r = dv ^ sv; wr = 1; end
    else if (op == 5) r = dv & sv;
    else known = 0;
    if (known) begin
      m_fl = {r == 0, r[31], c, v};
      if (wr) m_rf[d] = r;
    end
  endtask

  function automatic logic [11:0] fl(int d, int s, logic hi);
    logic [1:0] dd = 2'(d), ss = 2'(s);
    return hi ? {ss, dd, 8'h00} : {8'h00, ss, dd};
  endfunction

  task automatic apply(logic [2:0] op, logic [11:0] f, logic hi, logic ui, logic [31:0] im,
                       logic vld, string req);
    @(negedge clk);
    op_code = op; sel_fld = f; sel_hi = hi; use_imm = ui; imm = im; op_valid = vld;
    @(negedge clk);
    op_valid = 1'b0;
    if (vld) model_step(op, f, hi, ui, im);
    cmp_model(req);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_rf[i] = 0;
    m_fl = 0;
    repeat (3) @(negedge clk);
    cmp_model("R1");
    rst_n = 1'b1;

    apply(3, fl(0, 0, 0), 0, 1, 32'h7FFF_FFFF, 1, "R7");
    chk("R7", regs_out[31:0], 32'h7FFF_FFFF);
    apply(0, fl(0, 0, 0), 0, 1, 32'h1, 1, "R3");
    chk("R3", {28'd0, flags}, 32'h5);
    apply(3, fl(1, 0, 0), 0, 1, 32'hFFFF_FFFF, 1, "R9");
    chk("R9", {28'd0, flags}, 32'h4);
    apply(0, fl(1, 0, 0), 0, 1, 32'h1, 1, "R2");
    chk("R2", {28'd0, flags}, 32'hA);
    chk("R2", regs_out[63:32], 32'h0);
    apply(4, fl(2, 0, 1), 1, 1, 32'h5, 1, "R10");
    chk("R10", regs_out[95:64], 32'h5);
    apply(1, fl(2, 0, 0), 0, 1, 32'h7, 1, "R4");
    chk("R4", {28'd0, flags}, 32'h6);
    chk("R4", regs_out[95:64], 32'hFFFF_FFFE);
    apply(1, fl(0, 0, 0), 0, 1, 32'h1, 1, "R5");
    chk("R5", {28'd0, flags}, 32'h1);
    apply(2, fl(0, 0, 0), 0, 1, 32'h7FFF_FFFF, 1, "R6");
    chk("R6", {28'd0, flags}, 32'h8);
    apply(2, fl(2, 0, 0), 0, 0, 32'h0, 1, "R11");
    chk("R11", {28'd0, flags}, 32'h1);
    chk("R6", regs_out[95:64], 32'hFFFF_FFFE);
    apply(5, fl(2, 0, 0), 0, 1, 32'h8000_0000, 1, "R8");
    chk("R8", {28'd0, flags}, 32'h4);
    apply(5, fl(2, 0, 0), 0, 1, 32'h1, 1, "R8");
    chk("R8", {28'd0, flags}, 32'h8);
    apply(4, fl(3, 2, 1), 1, 0, 32'h0, 1, "R10");
    chk("R10", regs_out[127:96], 32'hFFFF_FFFE);
    apply(0, fl(3, 0, 0), 0, 1, 32'h3, 0, "R12");
    apply(6, fl(3, 0, 0), 0, 1, 32'h3, 1, "R12");
    apply(7, fl(0, 0, 0), 0, 1, 32'h3, 1, "R12");

    @(negedge clk);
    op_code = 3; sel_fld = fl(1, 0, 0); sel_hi = 0; use_imm = 1; imm = 32'h00F0_0000; op_valid = 1;
    @(posedge clk);
    #0;
    chk("R13", regs_out[63:32], m_rf[1]);
    @(negedge clk);
    op_valid = 0;
    model_step(3, fl(1, 0, 0), 0, 1, 32'h00F0_0000);
    cmp_model("R13");
    chk("R13", regs_out[63:32], 32'h00F0_0000);

    repeat (3) begin
      @(negedge clk);
      cmp_model("R12");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule